// File: doc/BRIEF.md
# Window Watchdog Timer

A supervisory timer that a processor must service through a small register bus. Software picks a short limit and a long limit, enables the timer and then writes a feed command at regular intervals. If the feed stops arriving before the long limit runs out, the watchdog declares a late fault. In window mode it also declares an early fault when a feed lands before the short limit has passed. This catches software that runs away by feeding too often, as well as software that hangs.

Time is measured in pulses of an external 1 µs tick strobe. The short limit is a base of 11 ticks shifted left by a 3-bit select. The long limit is the short limit times 2, 4, 8 or 16. On a fault the block either drives a fixed-length active-low reset pulse or raises a sticky interrupt, whichever is configured. A status register records whether the most recent fault was early or late.

Bus accesses are single-cycle strobes carrying an address, a write flag and a byte of data. Reads return their data one clock later. Address 0 is configuration, 1 is timeout, 2 is feed and 3 is status.

Top module: `win_wdog`

## Requirements
- R1: After reset, rst_no is 1, irq_o is 0, and configuration, timeout and status all read back as 0x00.
- R2: With timeout select `sel` in bits 6:4 and ratio `r` in bits 1:0 of the timeout register, the short limit is S = 11<<sel ticks and the long limit is L = S<<(r+1). When enabled and unfed, the L-th tick raises a late fault.
- R3: Configuration bit 2 = 0 selects window mode. In this mode a feed that arrives when fewer than S ticks have been counted is an early fault. A feed at S or more ticks is accepted. With bit 2 = 1, feeds are never early.
- R4: Writing data with bit 0 = 1 to the feed address (2) restarts the tick count. Bit 0 = 0 has no effect. A feed that arrives in the same cycle as a tick wins over that tick.
- R5: Configuration bits 1:0 = 01 enable the timer. Values 00, 10 and 11 leave it stopped with its count held at zero. The written value reads back unchanged.
- R6: With configuration bit 3 = 1, a fault drives rst_no low for exactly 16 clock cycles, starting two clock edges after the triggering tick or feed, and irq_o stays 0.
- R7: With configuration bit 3 = 0, a fault sets irq_o two edges after the trigger. irq_o stays 1, even with the timer disabled, until a configuration write with bit 7 = 1 clears it. Configuration bit 7 reads back the state of irq_o.
- R8: While the timer is enabled, writes to the timeout register and to configuration bit 2 are ignored.
- R9: The status register (address 3) bits 1:0 report the cause of the last fault: 01 for late, 10 for early, 00 if no fault has occurred since reset.
- R10: The count advances only on clock cycles with tick_i high.
- R11: A read strobe returns the addressed register on rdata_o after the clock edge that samples it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | One-cycle 1 µs time strobe |
| req_i | input | 1 | Bus access strobe |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 2 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, valid after the edge sampling the read |
| rst_no | output | 1 | Active-low fault reset pulse |
| irq_o | output | 1 | Sticky fault interrupt |

## Verification
A bus write takes effect at the edge that samples its strobe. Read data is valid just after that edge. A fault is registered one edge after its triggering tick or feed, and irq_o, rst_no and status change one edge after that. The bench drives and samples on falling edges and counts edges from the enabling write. Each late fault is therefore checked exactly: irq_o must still be low after L edges and must be high after L+1. The reset pulse is checked at its first and last low cycles and at the cycle it returns high. Window boundaries are tested with feeds at S-1 and S counted ticks, and at L-1 where the feed coincides with the expiring tick.

// File: rtl/win_wdog_pkg.sv
`timescale 1ns/1ps
package win_wdog_pkg;
  localparam int DATA_W  = 8;
  localparam int ADDR_W  = 2;
  localparam int SEL_LSB = 4;
  localparam logic [1:0] EN_RUN = 2'b01;

  typedef enum logic [ADDR_W-1:0] {
    A_CFG  = 2'd0,
    A_TMO  = 2'd1,
    A_FEED = 2'd2,
    A_STAT = 2'd3
  } addr_e;

  typedef enum logic [1:0] {
    CAUSE_NONE  = 2'b00,
    CAUSE_LATE  = 2'b01,
    CAUSE_EARLY = 2'b10
  } cause_e;
endpackage

// File: rtl/win_wdog_regs.sv
`timescale 1ns/1ps
module win_wdog_regs
  import win_wdog_pkg::*;
#(
  parameter int SEL_W   = 3,
  parameter int RATIO_W = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                req_i,
  input  logic                we_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [DATA_W-1:0]   wdata_i,
  output logic [DATA_W-1:0]   rdata_o,
  input  logic                irq_i,
  input  logic                fault_late_i,
  input  logic                fault_early_i,
  output logic                wd_en_o,
  output logic                tonly_o,
  output logic                act_rst_o,
  output logic [SEL_W-1:0]    sel_o,
  output logic [RATIO_W-1:0]  ratio_o,
  output logic                feed_o,
  output logic                irq_clr_o
);
  logic [1:0]          en_q;
  logic                tonly_q, act_q;
  logic [SEL_W-1:0]    sel_q;
  logic [RATIO_W-1:0]  ratio_q;
  cause_e              cause_q;
  logic [DATA_W-1:0]   rdata_q, rd_mux, tmo_view;
  logic                wr, rd, wd_en;

  assign wr    = req_i & we_i;
  assign rd    = req_i & ~we_i;
  assign wd_en = (en_q == EN_RUN);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q    <= '0;
      tonly_q <= 1'b0;
      act_q   <= 1'b0;
      sel_q   <= '0;
      ratio_q <= '0;
      cause_q <= CAUSE_NONE;
    end else begin
      if (wr && addr_i == A_CFG) begin
        en_q  <= wdata_i[1:0];
        act_q <= wdata_i[3];
        if (!wd_en) tonly_q <= wdata_i[2];  // mode locked while running
      end
      if (wr && addr_i == A_TMO && !wd_en) begin
        sel_q   <= wdata_i[SEL_LSB +: SEL_W];
        ratio_q <= wdata_i[0 +: RATIO_W];
      end
      if (fault_late_i)       cause_q <= CAUSE_LATE;
      else if (fault_early_i) cause_q <= CAUSE_EARLY;
    end
  end

  always_comb begin
    tmo_view = '0;
    tmo_view[SEL_LSB +: SEL_W] = sel_q;
    tmo_view[0 +: RATIO_W]     = ratio_q;
    unique case (addr_i)
      A_CFG:   rd_mux = {irq_i, 3'b000, act_q, tonly_q, en_q};
      A_TMO:   rd_mux = tmo_view;
      A_STAT:  rd_mux = {6'b0, cause_q};
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  rdata_q <= '0;
    else if (rd)  rdata_q <= rd_mux;
  end

  assign rdata_o   = rdata_q;
  assign wd_en_o   = wd_en;
  assign tonly_o   = tonly_q;
  assign act_rst_o = act_q;
  assign sel_o     = sel_q;
  assign ratio_o   = ratio_q;
  assign feed_o    = wr && addr_i == A_FEED && wdata_i[0];
  assign irq_clr_o = wr && addr_i == A_CFG && wdata_i[7];
endmodule

// File: rtl/win_wdog_timer.sv
`timescale 1ns/1ps
module win_wdog_timer #(
  parameter int BASE_TICKS = 11,
  parameter int SEL_W      = 3,
  parameter int RATIO_W    = 2,
  parameter int CNT_W      = 15
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               en_i,
  input  logic               tonly_i,
  input  logic [SEL_W-1:0]   sel_i,
  input  logic [RATIO_W-1:0] ratio_i,
  input  logic               tick_i,
  input  logic               feed_i,
  output logic               fault_late_o,
  output logic               fault_early_o,
  output logic [CNT_W-1:0]   cnt_o,
  output logic [CNT_W-1:0]   long_lim_o
);
  logic [CNT_W-1:0]   cnt_q, short_lim, long_lim;
  logic [RATIO_W:0]   ratio_sh;
  logic               late_q, early_q;

  assign ratio_sh  = {1'b0, ratio_i} + 1'b1;
  assign short_lim = CNT_W'(BASE_TICKS) << sel_i;
  assign long_lim  = short_lim << ratio_sh;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      late_q  <= 1'b0;
      early_q <= 1'b0;
    end else begin
      late_q  <= 1'b0;
      early_q <= 1'b0;
      if (!en_i) begin
        cnt_q <= '0;
      end else if (feed_i) begin
        cnt_q <= '0;
        if (!tonly_i && cnt_q < short_lim) early_q <= 1'b1;
      end else if (tick_i) begin
        if (cnt_q >= long_lim - CNT_W'(1)) begin
          cnt_q  <= '0;
          late_q <= 1'b1;
        end else begin
          cnt_q <= cnt_q + CNT_W'(1);
        end
      end
    end
  end

  assign fault_late_o  = late_q;
  assign fault_early_o = early_q;
  assign cnt_o         = cnt_q;
  assign long_lim_o    = long_lim;
endmodule

// File: rtl/win_wdog_action.sv
`timescale 1ns/1ps
module win_wdog_action #(
  parameter int RST_PULSE = 16,
  parameter int PCNT_W    = 5
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fault_i,
  input  logic act_rst_i,
  input  logic irq_clr_i,
  output logic rst_no,
  output logic irq_o
);
  logic [PCNT_W-1:0] pcnt_q;
  logic              irq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pcnt_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      if (fault_i && act_rst_i)  pcnt_q <= PCNT_W'(RST_PULSE);
      else if (pcnt_q != '0)     pcnt_q <= pcnt_q - PCNT_W'(1);
      // set wins over a coincident clear
      if (fault_i && !act_rst_i) irq_q <= 1'b1;
      else if (irq_clr_i)        irq_q <= 1'b0;
    end
  end

  assign rst_no = (pcnt_q == '0);
  assign irq_o  = irq_q;
endmodule

// File: rtl/win_wdog.sv
`timescale 1ns/1ps
module win_wdog
  import win_wdog_pkg::*;
#(
  parameter int BASE_TICKS = 11,
  parameter int SEL_W      = 3,
  parameter int RATIO_W    = 2,
  parameter int RST_PULSE  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rst_no,
  output logic              irq_o
);
  localparam int CNT_W  = $clog2(BASE_TICKS + 1) + (2**SEL_W - 1) + 2**RATIO_W;
  localparam int PCNT_W = $clog2(RST_PULSE + 1);

  logic               wd_en, tonly, act_rst, feed, irq_clr;
  logic               fault_late, fault_early;
  logic [SEL_W-1:0]   sel;
  logic [RATIO_W-1:0] ratio;
  logic [CNT_W-1:0]   cnt, long_lim;

  win_wdog_regs #(.SEL_W(SEL_W), .RATIO_W(RATIO_W)) u_regs (
    .clk_i, .rst_ni, .req_i, .we_i, .addr_i, .wdata_i, .rdata_o,
    .irq_i         (irq_o),
    .fault_late_i  (fault_late),
    .fault_early_i (fault_early),
    .wd_en_o       (wd_en),
    .tonly_o       (tonly),
    .act_rst_o     (act_rst),
    .sel_o         (sel),
    .ratio_o       (ratio),
    .feed_o        (feed),
    .irq_clr_o     (irq_clr)
  );

  win_wdog_timer #(
    .BASE_TICKS(BASE_TICKS), .SEL_W(SEL_W), .RATIO_W(RATIO_W), .CNT_W(CNT_W)
  ) u_timer (
    .clk_i, .rst_ni,
    .en_i          (wd_en),
    .tonly_i       (tonly),
    .sel_i         (sel),
    .ratio_i       (ratio),
    .tick_i,
    .feed_i        (feed),
    .fault_late_o  (fault_late),
    .fault_early_o (fault_early),
    .cnt_o         (cnt),
    .long_lim_o    (long_lim)
  );

  win_wdog_action #(.RST_PULSE(RST_PULSE), .PCNT_W(PCNT_W)) u_action (
    .clk_i, .rst_ni,
    .fault_i   (fault_late | fault_early),
    .act_rst_i (act_rst),
    .irq_clr_i (irq_clr),
    .rst_no,
    .irq_o
  );
endmodule

// File: rtl/win_wdog_chk.sv
`timescale 1ns/1ps
module win_wdog_chk #(
  parameter int CNT_W     = 15,
  parameter int SEL_W     = 3,
  parameter int RATIO_W   = 2,
  parameter int RST_PULSE = 16
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               req_i,
  input logic               we_i,
  input logic [1:0]         addr_i,
  input logic [7:0]         wdata_i,
  input logic               rst_no,
  input logic               irq_o,
  input logic               wd_en,
  input logic               tonly,
  input logic [SEL_W-1:0]   sel,
  input logic [RATIO_W-1:0] ratio,
  input logic               fault_late,
  input logic               fault_early,
  input logic [CNT_W-1:0]   cnt,
  input logic [CNT_W-1:0]   long_lim
);
  localparam int LW = $clog2(RST_PULSE + 2);
  logic [LW-1:0] low_run;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          low_run <= '0;
    else if (rst_no)                      low_run <= '0;
    else if (low_run != LW'(RST_PULSE+1)) low_run <= low_run + LW'(1);
  end

  // R2
  cnt_in_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt < long_lim);

  // R3
  early_only_window_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_early |-> !$past(tonly));

  // R5
  no_fault_when_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(wd_en) |-> !(fault_late || fault_early));

  // R6
  rst_pulse_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_no) |-> low_run == LW'(RST_PULSE));

  // R6
  rst_pulse_max_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    low_run <= LW'(RST_PULSE));

  // R7
  irq_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !(req_i && we_i && addr_i == 2'd0 && wdata_i[7])) |=> irq_o);

  // R7
  irq_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past(fault_late || fault_early));

  // R8
  tmo_locked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(wd_en) |-> ($stable(sel) && $stable(ratio) && $stable(tonly)));
endmodule

bind win_wdog win_wdog_chk #(
  .CNT_W(CNT_W), .SEL_W(SEL_W), .RATIO_W(RATIO_W), .RST_PULSE(RST_PULSE)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_i       (req_i),
  .we_i        (we_i),
  .addr_i      (addr_i),
  .wdata_i     (wdata_i),
  .rst_no      (rst_no),
  .irq_o       (irq_o),
  .wd_en       (wd_en),
  .tonly       (tonly),
  .sel         (sel),
  .ratio       (ratio),
  .fault_late  (fault_late),
  .fault_early (fault_early),
  .cnt         (cnt),
  .long_lim    (long_lim)
);

// File: tb/win_wdog_tb.sv
`timescale 1ns/1ps
module win_wdog_tb;
  import win_wdog_pkg::*;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b1;
  logic       req = 1'b0, we = 1'b0;
  logic [1:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       rst_n_out, irq;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  win_wdog u_dut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .req_i(req), .we_i(we),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .rst_no(rst_n_out), .irq_o(irq)
  );

  typedef struct packed {
    logic [2:0]  sel;
    logic [1:0]  ratio;
    logic        tonly;
    logic        feed;
    logic [15:0] k;
    logic [1:0]  cause;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    '{3'd0, 2'd0, 1'b0, 1'b1, 16'd5,  2'b10},
    '{3'd0, 2'd0, 1'b0, 1'b1, 16'd10, 2'b10},
    '{3'd0, 2'd0, 1'b0, 1'b1, 16'd11, 2'b00},
    '{3'd0, 2'd0, 1'b1, 1'b1, 16'd0,  2'b00},
    '{3'd0, 2'd0, 1'b0, 1'b1, 16'd21, 2'b00},
    '{3'd0, 2'd0, 1'b1, 1'b0, 16'd0,  2'b01},
    '{3'd1, 2'd1, 1'b0, 1'b0, 16'd0,  2'b01},
    '{3'd2, 2'd0, 1'b0, 1'b1, 16'd43, 2'b10},
    '{3'd2, 2'd0, 1'b0, 1'b1, 16'd44, 2'b00},
    '{3'd0, 2'd3, 1'b1, 1'b0, 16'd0,  2'b01},
    '{3'd3, 2'd2, 1'b0, 1'b1, 16'd87, 2'b10}
  };

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(posedge clk);
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    req = 1'b1; we = 1'b0; addr = a;
    @(posedge clk);
    @(negedge clk);
    d = rdata;
    req = 1'b0;
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired got=running exp=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    idle(3);
    rst_n = 1'b1;
    idle(1);

    // R1 reset state
    chk("R1 rst_no", 32'(rst_n_out), 1);
    chk("R1 irq", 32'(irq), 0);
    rd(A_CFG, d);  chk("R1 cfg R11", 32'(d), 0);
    rd(A_TMO, d);  chk("R1 tmo", 32'(d), 0);
    rd(A_STAT, d); chk("R1 status", 32'(d), 0);

    // vector table: R2 late limits, R3 window, R9 cause
    for (int i = 0; i < NV; i++) begin
      vec_t v;
      int s, l;
      v = VECS[i];
      s = 11 << v.sel;
      l = s << (int'(v.ratio) + 1);
      wr(A_CFG, 8'h80);
      wr(A_TMO, {1'b0, v.sel, 2'b00, v.ratio});
      wr(A_CFG, {5'b0, v.tonly, 2'b01});
      if (v.feed) begin
        idle(int'(v.k));
        wr(A_FEED, 8'h01);
        idle(2);
        chk($sformatf("R3 R4 vec %0d irq", i), 32'(irq), 32'(v.cause != 2'b00));
        if (v.cause != 2'b00) begin
          rd(A_STAT, d);
          chk($sformatf("R9 vec %0d early cause", i), 32'(d), 32'(v.cause));
        end
      end else begin
        idle(l);
        chk($sformatf("R2 vec %0d before limit", i), 32'(irq), 0);
        idle(1);
        chk($sformatf("R2 vec %0d at limit", i), 32'(irq), 1);
        rd(A_STAT, d);
        chk($sformatf("R9 vec %0d late cause", i), 32'(d), 32'(v.cause));
      end
    end

    // R6 reset action, L = 22
    wr(A_CFG, 8'h80);
    wr(A_TMO, 8'h00);
    wr(A_CFG, 8'h0D);
    idle(22); chk("R6 rst before", 32'(rst_n_out), 1);
    idle(1);  chk("R6 rst first low", 32'(rst_n_out), 0);
    idle(15); chk("R6 rst last low", 32'(rst_n_out), 0);
    idle(1);  chk("R6 rst released", 32'(rst_n_out), 1);
    chk("R6 no irq", 32'(irq), 0);
    wr(A_CFG, 8'h80);

    // R4 feed write with bit0 = 0 does not restart
    wr(A_CFG, 8'h05);
    idle(10);
    wr(A_FEED, 8'hFE);
    idle(11); chk("R4 zero feed before", 32'(irq), 0);
    idle(1);  chk("R4 zero feed ignored", 32'(irq), 1);

    // R8 lock while enabled
    wr(A_CFG, 8'h80);
    wr(A_TMO, 8'h00);
    wr(A_CFG, 8'h05);
    wr(A_TMO, 8'h73);
    wr(A_CFG, 8'h01);
    rd(A_TMO, d); chk("R8 tmo locked", 32'(d), 32'h00);
    rd(A_CFG, d); chk("R8 mode locked", 32'(d), 32'h05);
    idle(18); chk("R8 old limit before", 32'(irq), 0);
    idle(1);  chk("R8 old limit kept", 32'(irq), 1);

    // R5 encoding 10 stays stopped
    wr(A_CFG, 8'h80);
    wr(A_CFG, 8'h02);
    rd(A_CFG, d); chk("R5 readback 10", 32'(d), 32'h02);
    idle(40);
    chk("R5 no irq when 10", 32'(irq), 0);
    chk("R5 no rst when 10", 32'(rst_n_out), 1);

    // R10 no tick, no time
    wr(A_CFG, 8'h80);
    tick = 1'b0;
    wr(A_CFG, 8'h05);
    idle(100); chk("R10 no tick no fault", 32'(irq), 0);
    tick = 1'b1;
    idle(22); chk("R10 before limit", 32'(irq), 0);
    idle(1);  chk("R10 at limit", 32'(irq), 1);

    // R7 sticky irq and clear
    wr(A_CFG, 8'h00);
    idle(5);
    chk("R7 irq sticky while off", 32'(irq), 1);
    rd(A_CFG, d); chk("R7 cfg bit7 shows irq", 32'(d[7]), 1);
    wr(A_CFG, 8'h80);
    chk("R7 irq cleared", 32'(irq), 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule